// File: doc/BRIEF.md
# ALU Status Flag Register

This block keeps the processor status byte of a small 8-bit core. Four arithmetic flags live in the byte: carry, half-carry, zero and overflow. The block works them out itself from the ALU operands, the carry input, the result and an operation class, so the ALU datapath only has to pass its inputs and its result across. Each of the four flags has its own update enable, which lets the instruction decoder choose which flags an instruction changes. Software can also write the arithmetic flags directly through a CPU write port.

Two more bits record system state: a power-down bit and a watchdog-expiry bit. Software cannot write either of them. They change only on strobes from the system, which are power-up, watchdog expiry, the watchdog-clear instruction and the sleep instruction.

Every change appears on the output one clock edge after the cycle in which the inputs were presented. When no update, write or strobe is present, the register holds its value.

Top module: `alu_status_reg`

## Requirements
- R1: The status byte uses this layout: carry at bit 0, half-carry at bit 1, zero at bit 2, overflow at bit 3, power-down at bit 4 and watchdog-expiry at bit 5. Bits 7:6 always read 0. After reset the whole byte is 0.
- R2: For op_class 0 (add), the result is a + b + alu_cin. Carry takes the carry out of bit 7. Half-carry takes the carry out of bit 3.
- R3: For op_class 1 (subtract), the operation is a − b − (1 − alu_cin). Carry is 1 when no borrow leaves bit 7. Half-carry is 1 when no borrow crosses from the high nibble into the low nibble.
- R4: For add and subtract, overflow is the XOR of the carry into bit 7 and the carry out of bit 7. This equals signed overflow of the operation.
- R5: Zero is set when alu_res is 0 and cleared otherwise. It is updated for op_class 0, 1 and 3. Op_class 2 leaves zero unchanged.
- R6: For op_class 2 (rotate through carry), carry loads rot_bit. For op_class 3 (logic), carry, half-carry and overflow are not changed.
- R7: A flag whose bit in flag_we (bit n for status bit n) is 0 keeps its value.
- R8: A CPU write loads cpu_wdata[3:0] into bits 3:0. It leaves power-down and watchdog-expiry unchanged.
- R9: When an ALU update and a CPU write hit the same arithmetic flag in the same cycle, the ALU value is stored. Flags the ALU does not update take the CPU value.
- R10: Sleep sets power-down. Watchdog-clear clears it. When both occur in the same cycle, sleep wins.
- R11: Watchdog expiry sets watchdog-expiry. Watchdog-clear or sleep clears it. When expiry coincides with either of them, expiry wins.
- R12: The power-up strobe clears all bits and overrides every other input in that cycle.
- R13: Changes appear after the next rising clock edge. With no update, write or strobe, the byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_class | input | 2 | 0 add, 1 subtract, 2 rotate through carry, 3 logic |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand (subtrahend for subtract) |
| alu_cin | input | 1 | Carry in; for subtract, 1 means no borrow in |
| alu_res | input | 8 | ALU result, used for the zero flag |
| rot_bit | input | 1 | Bit shifted out by a rotate through carry |
| flag_we | input | 4 | Per-flag update enables for bits 3:0 |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data (bits 3:0 used) |
| ev_por | input | 1 | Power-up strobe |
| ev_wdt_to | input | 1 | Watchdog expiry strobe |
| ev_clrwdt | input | 1 | Watchdog-clear instruction strobe |
| ev_halt | input | 1 | Sleep instruction strobe |
| status_q | output | 8 | Status byte |

## Verification
Every result is due exactly one rising edge after its stimulus. This holds for ALU flag updates, CPU writes, system strobes and the power-up clear. The bench drives inputs on a falling edge and reads status_q on the next falling edge, half a period after the only register stage has loaded. It returns all strobes to idle before the following stimulus, so each check sees one update. After reset, the bench waits out the two-stage reset synchronizer before it takes the first reading.

// File: rtl/status_pkg.sv
package status_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_ROT   = 2'd2,
    OP_LOGIC = 2'd3
  } op_class_e;

  localparam int unsigned STATUS_W    = 8;
  localparam int unsigned ARITH_FLAGS = 4;
  localparam int unsigned BIT_C       = 0;
  localparam int unsigned BIT_AC      = 1;
  localparam int unsigned BIT_Z       = 2;
  localparam int unsigned BIT_OV      = 3;
  localparam int unsigned BIT_PD      = 4;
  localparam int unsigned BIT_TO      = 5;

endpackage

// File: rtl/status_arith_flags.sv
module status_arith_flags
  import status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_class_e               op,
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  input  logic                    cin,
  input  logic [DATA_W-1:0]       res,
  input  logic                    rot_bit,
  output logic [ARITH_FLAGS-1:0]  flag_val,
  output logic [ARITH_FLAGS-1:0]  flag_def
);

  localparam int unsigned NIB_W = DATA_W / 2;
  localparam int unsigned LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full_sum;
  logic [NIB_W:0]    nib_sum;
  logic [LOW_W:0]    low_sum;
  logic              is_arith;
  logic              is_rot;

  // Subtraction is formed as a + ~b + cin, so a carry out means no borrow.
  always_comb begin
    b_eff    = (op == OP_SUB) ? ~b : b;
    is_arith = (op == OP_ADD) || (op == OP_SUB);
    is_rot   = (op == OP_ROT);
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
  end

  always_comb begin
    flag_val[BIT_C]  = is_rot ? rot_bit : full_sum[DATA_W];
    flag_def[BIT_C]  = is_arith || is_rot;
    flag_val[BIT_AC] = nib_sum[NIB_W];
    flag_def[BIT_AC] = is_arith;
    flag_val[BIT_Z]  = (res == '0);
    flag_def[BIT_Z]  = !is_rot;
    flag_val[BIT_OV] = low_sum[LOW_W] ^ full_sum[DATA_W];
    flag_def[BIT_OV] = is_arith;
  end

  always_comb begin
    assert (!(op == OP_LOGIC) || (flag_def == 4'b0100))
      else $error("p_logic_only_z_r6");
  end

endmodule

// File: rtl/status_arith_reg.sv
module status_arith_reg
  import status_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [ARITH_FLAGS-1:0]  upd,
  input  logic [ARITH_FLAGS-1:0]  val,
  input  logic                    cpu_we,
  input  logic [ARITH_FLAGS-1:0]  cpu_wdata,
  output logic [ARITH_FLAGS-1:0]  q
);

  logic [ARITH_FLAGS-1:0] nxt;
  logic [ARITH_FLAGS-1:0] en;

  for (genvar i = 0; i < ARITH_FLAGS; i++) begin : g_flag
    // Priority per bit: power-up clear, ALU update, CPU write.
    always_comb begin
      en[i] = clr || upd[i] || cpu_we;
      if (clr)          nxt[i] = 1'b0;
      else if (upd[i])  nxt[i] = val[i];
      else              nxt[i] = cpu_wdata[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= 1'b0;
      else if (en[i]) q[i] <= nxt[i];
    end

    p_alu_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd[i] && !clr) |=> (q[i] == $past(val[i])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd[i] && !clr && !cpu_we) |=> $stable(q[i]));
  end

  p_cpu_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && upd == '0 && !clr) |=> (q == $past(cpu_wdata)));

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

endmodule

// File: rtl/status_sys_flags.sv
module status_sys_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_por,
  input  logic ev_wdt_to,
  input  logic ev_clrwdt,
  input  logic ev_halt,
  output logic pd_q,
  output logic to_q
);

  logic pd_nxt;
  logic to_nxt;
  logic pd_en;
  logic to_en;

  always_comb begin
    pd_en = ev_por || ev_halt || ev_clrwdt;
    if (ev_por)       pd_nxt = 1'b0;
    else if (ev_halt) pd_nxt = 1'b1;
    else              pd_nxt = 1'b0;

    to_en = ev_por || ev_wdt_to || ev_clrwdt || ev_halt;
    if (ev_por)          to_nxt = 1'b0;
    else if (ev_wdt_to)  to_nxt = 1'b1;
    else                 to_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else begin
      if (pd_en) pd_q <= pd_nxt;
      if (to_en) to_q <= to_nxt;
    end
  end

  p_halt_sets_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_halt && !ev_por) |=> pd_q);

  p_clr_clears_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clrwdt && !ev_halt) |=> !pd_q);

  p_expiry_sets_to_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_to && !ev_por) |=> to_q);

  p_to_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_clrwdt || ev_halt) && !ev_wdt_to) |=> !to_q);

  p_sys_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_por && !ev_wdt_to && !ev_clrwdt && !ev_halt) |=> ($stable(pd_q) && $stable(to_q)));

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic              alu_cin,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              rot_bit,
  input  logic [3:0]        flag_we,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  input  logic              ev_por,
  input  logic              ev_wdt_to,
  input  logic              ev_clrwdt,
  input  logic              ev_halt,
  output logic [7:0]        status_q
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]  rst_pipe;
  logic                    rst_int_n;
  logic [ARITH_FLAGS-1:0]  flag_val;
  logic [ARITH_FLAGS-1:0]  flag_def;
  logic [ARITH_FLAGS-1:0]  flag_upd;
  logic [ARITH_FLAGS-1:0]  arith_q;
  logic                    pd_q;
  logic                    to_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  status_arith_flags #(.DATA_W(DATA_W)) u_flags (
    .op       (op_class_e'(op_class)),
    .a        (alu_a),
    .b        (alu_b),
    .cin      (alu_cin),
    .res      (alu_res),
    .rot_bit  (rot_bit),
    .flag_val (flag_val),
    .flag_def (flag_def)
  );

  assign flag_upd = flag_we & flag_def;

  status_arith_reg u_arith (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (ev_por),
    .upd       (flag_upd),
    .val       (flag_val),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata[ARITH_FLAGS-1:0]),
    .q         (arith_q)
  );

  status_sys_flags u_sys (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ev_por    (ev_por),
    .ev_wdt_to (ev_wdt_to),
    .ev_clrwdt (ev_clrwdt),
    .ev_halt   (ev_halt),
    .pd_q      (pd_q),
    .to_q      (to_q)
  );

  assign status_q = {2'b00, to_q, pd_q, arith_q};

  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    status_q[7:6] == 2'b00);

  p_por_clears_all_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    ev_por |=> (status_q == 8'h00));

  p_rotate_keeps_z_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_class == 2'd2 && !cpu_we && !ev_por) |=> $stable(status_q[BIT_Z]));

  p_logic_keeps_arith_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_class == 2'd3 && !cpu_we && !ev_por) |=>
      ($stable(status_q[BIT_C]) && $stable(status_q[BIT_AC]) && $stable(status_q[BIT_OV])));

endmodule

// File: tb/alu_status_reg_tb_top.sv
`timescale 1ns/1ps
module alu_status_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_class;
  logic [7:0] alu_a, alu_b, alu_res, cpu_wdata;
  logic       alu_cin, rot_bit, cpu_we;
  logic [3:0] flag_we;
  logic       ev_por, ev_wdt_to, ev_clrwdt, ev_halt;
  logic [7:0] status_q;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  alu_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .alu_a(alu_a), .alu_b(alu_b),
    .alu_cin(alu_cin), .alu_res(alu_res), .rot_bit(rot_bit), .flag_we(flag_we),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .ev_por(ev_por), .ev_wdt_to(ev_wdt_to),
    .ev_clrwdt(ev_clrwdt), .ev_halt(ev_halt), .status_q(status_q)
  );

  // Entry: op(2) a(8) b(8) cin(1) res(8) rot(1) expected {ov,z,ac,c}(4)
  localparam int NVEC = 16;
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 1'b0, 4'b0010},
    {2'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b0, 4'b0111},
    {2'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 4'b1010},
    {2'd0, 8'h80, 8'h80, 1'b0, 8'h00, 1'b0, 4'b1101},
    {2'd1, 8'h05, 8'h03, 1'b1, 8'h02, 1'b0, 4'b0011},
    {2'd1, 8'h03, 8'h05, 1'b1, 8'hFE, 1'b0, 4'b0000},
    {2'd1, 8'h10, 8'h01, 1'b1, 8'h0F, 1'b0, 4'b0001},
    {2'd1, 8'h80, 8'h01, 1'b1, 8'h7F, 1'b0, 4'b1001},
    {2'd1, 8'h42, 8'h42, 1'b1, 8'h00, 1'b0, 4'b0111},
    {2'd0, 8'h08, 8'h08, 1'b1, 8'h11, 1'b0, 4'b0010},
    {2'd1, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 4'b0000},
    {2'd3, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 4'b0100},
    {2'd3, 8'h00, 8'h00, 1'b0, 8'h5A, 1'b0, 4'b0000},
    {2'd2, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'b0001},
    {2'd3, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 4'b0101},
    {2'd2, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 4'b0100}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: status_q=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_class = 2'd3; alu_a = '0; alu_b = '0; alu_cin = 1'b0; alu_res = 8'h01;
    rot_bit = 1'b0; flag_we = '0; cpu_we = 1'b0; cpu_wdata = '0;
    ev_por = 1'b0; ev_wdt_to = 1'b0; ev_clrwdt = 1'b0; ev_halt = 1'b0;
  endtask

  // Inputs set by the caller on a falling edge; one rising edge loads them.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", status_q, 8'h00);

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < NVEC; i++) begin
      op_class = VEC[i][31:30]; alu_a = VEC[i][29:22]; alu_b = VEC[i][21:14];
      alu_cin = VEC[i][13]; alu_res = VEC[i][12:5]; rot_bit = VEC[i][4];
      flag_we = 4'hF;
      step();
      check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), status_q, {4'h0, VEC[i][3:0]});
    end

    // R7: disabled flags hold
    op_class = 2'd0; alu_a = 8'hFF; alu_b = 8'h01; alu_res = 8'h00; flag_we = 4'h0;
    step();
    check("R7 update enables low", status_q, 8'h04);

    step();
    check("R13 idle hold", status_q, 8'h04);

    cpu_we = 1'b1; cpu_wdata = 8'hFF;
    step();
    check("R8 write upper bits ignored", status_q, 8'h0F);

    ev_halt = 1'b1;
    step();
    check("R10 sleep sets PD", status_q, 8'h1F);

    cpu_we = 1'b1; cpu_wdata = 8'h00;
    step();
    check("R8 write keeps PD", status_q, 8'h10);

    cpu_we = 1'b1; cpu_wdata = 8'h0F; op_class = 2'd3; alu_res = 8'h33; flag_we = 4'hF;
    step();
    check("R9 logic Z beats write", status_q, 8'h1B);

    cpu_we = 1'b1; cpu_wdata = 8'h00; op_class = 2'd0; alu_a = 8'hFF; alu_b = 8'h01;
    alu_res = 8'h00; flag_we = 4'hF;
    step();
    check("R9 add flags beat write", status_q, 8'h17);

    ev_wdt_to = 1'b1;
    step();
    check("R11 expiry sets TO", status_q, 8'h37);

    ev_clrwdt = 1'b1;
    step();
    check("R10 R11 clear clears PD TO", status_q, 8'h07);

    ev_clrwdt = 1'b1; ev_halt = 1'b1;
    step();
    check("R10 sleep wins over clear", status_q, 8'h17);

    ev_wdt_to = 1'b1; ev_halt = 1'b1;
    step();
    check("R11 expiry wins over sleep", status_q, 8'h37);

    ev_wdt_to = 1'b1; ev_clrwdt = 1'b1;
    step();
    check("R11 expiry wins over clear", status_q, 8'h27);

    ev_halt = 1'b1;
    step();
    check("R11 sleep clears TO", status_q, 8'h17);

    ev_por = 1'b1; cpu_we = 1'b1; cpu_wdata = 8'hFF; ev_wdt_to = 1'b1; ev_halt = 1'b1;
    op_class = 2'd0; alu_a = 8'hFF; alu_b = 8'h01; alu_res = 8'h00; flag_we = 4'hF;
    step();
    check("R12 power-up clears all", status_q, 8'h00);

    op_class = 2'd2; rot_bit = 1'b1; flag_we = 4'b1110;
    step();
    check("R7 rotate with C disabled", status_q, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule